// File: doc/BRIEF.md
# Test Access Port Controller with Four-Bit Instruction Decode

This block is the test access port of a chip: a five-pin serial test interface (clock, mode select, data in, data out, optional asynchronous reset) driving the standard sixteen-state controller. Its instruction register is four bits wide. The upper two bits choose one of four families of data registers, and a few exact codes pick a variant inside a family. The boundary cells and the logic under self-test are modelled here as plain shift registers, so the block can be exercised on its own.

Besides the usual boundary and bypass paths, the controller reaches an on-chip status word and a self-test control word. One instruction launches a built-in self-test: a linear feedback shift register seeded from the control word runs for a fixed count of test clocks (10240 by default). Its signature, together with running and finished flags, is then read back through the status path. Test data out changes on the falling test clock edge and is enabled only while a shift state is active.

Top module: `testPortTop`

## Requirements
- R1: An active-low `trstN` asynchronously forces the Test-Logic-Reset state, the bypass instruction (`selPath` = 5), `tdoOe` = 0, `bsOut` = 0, a zero control word and an idle, unfinished self-test.
- R2: From any state, five consecutive rising `tck` edges with `tms` high reach Test-Logic-Reset, and the instruction register holds 1111 (bypass) in that state; four such edges from Shift-DR are not enough.
- R3: In Capture-IR the instruction shift register loads 0001. In Shift-IR it shifts right with `tdi` entering bit 3 and bit 0 driving `tdo`. Update-IR copies it into the instruction register.
- R4: Codes 11xx select a one-bit bypass register that captures 0, so data out is data in delayed by one shift.
- R5: Codes 00xx other than 0011 select the `BS_W`-bit boundary chain. Capture-DR loads `bsIn`, the chain shifts out bit 0 first, and Update-DR copies the chain onto `bsOut`.
- R6: Code 0011 selects the boundary chain preceded by a 32-bit identification word. The first 32 bits shifted out are `ID_CODE` (bit 0 first) and the next `BS_W` bits are `bsIn`. Update-DR leaves `bsOut` unchanged.
- R7: Codes 10xx select a path whose shifted-out bits are always 0.
- R8: Code 0101 selects the `CTL_W`-bit self-test control word. Capture-DR loads its current value and Update-DR writes the shifted value.
- R9: Update-IR with code 0100 starts the self-test. The signature is seeded from the control word and makes one Galois step per rising `tck`: shift right, and XOR `LFSR_TAPS` (default 8'hB8) when the bit shifted out is 1. This runs for exactly `BIST_CYCLES` edges, with `bistBusy` high throughout and the finished flag set at the end. Running and finished are never both set.
- R10: Codes 01xx other than 0101 select the status word of `CTL_W`+2 bits. Capture-DR loads the pre-edge signature in bits `CTL_W`-1..0, the running flag in bit `CTL_W` and the finished flag in bit `CTL_W`+1, and the word shifts out bit 0 first.
- R11: `tdo` and `tdoOe` change only on the falling `tck` edge. `tdoOe` is 1 exactly while the controller is in Shift-DR or Shift-IR.
- R12: `drCapture`, `drShift` and `drUpdate` are high exactly in Capture-DR, Shift-DR and Update-DR. `selPath` reports the decoded path: 0 boundary, 1 identification chain, 2 status, 3 self-test control, 4 zero, 5 bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial test data in |
| bsIn | input | BS_W | Parallel values captured by the boundary chain |
| tdo | output | 1 | Serial test data out, updated on falling `tck` |
| tdoOe | output | 1 | Output enable for `tdo` |
| bsOut | output | BS_W | Boundary update outputs |
| selPath | output | 3 | Decoded data-register path |
| drCapture | output | 1 | Capture-DR strobe |
| drShift | output | 1 | Shift-DR strobe |
| drUpdate | output | 1 | Update-DR strobe |
| bistBusy | output | 1 | Self-test running |

## Verification
The self-test's final signature step and a Capture-DR of the status word can fall on the same rising edge. The bench provokes this by idling in Run-Test/Idle until exactly three edges remain in the run, then scanning the status word so that its capture edge is the last counting edge. The capture must show the running flag set, the finished flag clear and a signature one step short of the end. A second scan must then show the finished flag and the full-length signature. A behavioural reference that updates on every clock judges both scans, alongside directed expected values computed from the stepping rule.

// File: rtl/testPortPkg.sv
package testPortPkg;

  localparam int IR_W = 4;
  localparam logic [IR_W-1:0] IR_RESET_CODE   = 4'b1111;
  localparam logic [IR_W-1:0] IR_CAPTURE_CODE = 4'b0001;
  localparam logic [IR_W-1:0] IR_IDCHAIN_CODE = 4'b0011;
  localparam logic [IR_W-1:0] IR_BISTRUN_CODE = 4'b0100;
  localparam logic [IR_W-1:0] IR_STCTL_CODE   = 4'b0101;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE, ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR,
    ST_UPD_DR, ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tapState_t;

  typedef enum logic [2:0] {
    PATH_BSCAN = 3'd0,
    PATH_IDCH  = 3'd1,
    PATH_STAT  = 3'd2,
    PATH_STCTL = 3'd3,
    PATH_ZERO  = 3'd4,
    PATH_BYP   = 3'd5
  } drPath_t;

  typedef struct packed {
    logic    capDr;
    logic    shDr;
    logic    updDr;
    logic    shIr;
    logic    irBit;
    logic    bistGo;
    drPath_t path;
  } tapStb_t;

  function automatic tapState_t tapNext(input tapState_t cur, input logic tmsIn);
    tapState_t nxt;
    unique case (cur)
      ST_RESET:  nxt = tmsIn ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxt = tmsIn ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nxt = tmsIn ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tmsIn ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tmsIn ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tmsIn ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tmsIn ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tmsIn ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tmsIn ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nxt = tmsIn ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nxt = tmsIn ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tmsIn ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tmsIn ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tmsIn ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tmsIn ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tmsIn ? ST_SEL_DR : ST_IDLE;
      default:   nxt = ST_RESET;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/testPortCtl.sv
module testPortCtl
  import testPortPkg::*;
(
  input  logic    tck,
  input  logic    trstN,
  input  logic    tms,
  input  logic    tdi,
  output tapStb_t stb
);

  tapState_t curSt;
  tapState_t nxtSt;
  logic [IR_W-1:0] irShift;
  logic [IR_W-1:0] irReg;
  drPath_t pathSel;

  always_comb nxtSt = tapNext(curSt, tms);

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) curSt <= ST_RESET;
    else        curSt <= nxtSt;
  end

  // instruction shift stage and the held instruction
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irShift <= IR_CAPTURE_CODE;
    end else if (curSt == ST_CAP_IR) begin
      irShift <= IR_CAPTURE_CODE;
    end else if (curSt == ST_SH_IR) begin
      irShift <= {tdi, irShift[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irReg <= IR_RESET_CODE;
    end else if (nxtSt == ST_RESET) begin
      irReg <= IR_RESET_CODE;
    end else if (curSt == ST_UPD_IR) begin
      irReg <= irShift;
    end
  end

  // family from the top two bits, exact codes pick the variant
  always_comb begin
    unique case (irReg[3:2])
      2'b00:   pathSel = (irReg == IR_IDCHAIN_CODE) ? PATH_IDCH : PATH_BSCAN;
      2'b01:   pathSel = (irReg == IR_STCTL_CODE) ? PATH_STCTL : PATH_STAT;
      2'b10:   pathSel = PATH_ZERO;
      default: pathSel = PATH_BYP;
    endcase
  end

  always_comb begin
    stb.capDr  = (curSt == ST_CAP_DR);
    stb.shDr   = (curSt == ST_SH_DR);
    stb.updDr  = (curSt == ST_UPD_DR);
    stb.shIr   = (curSt == ST_SH_IR);
    stb.irBit  = irShift[0];
    stb.bistGo = (curSt == ST_UPD_IR) && (irShift == IR_BISTRUN_CODE);
    stb.path   = pathSel;
  end

  AST_FIVE_HIGH_RESET: assert property (@(posedge tck) disable iff (!trstN) (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4)) |=> (curSt == ST_RESET)); // R2
  AST_RESET_HOLDS_BYPASS: assert property (@(posedge tck) disable iff (!trstN) (curSt == ST_RESET) |-> (irReg == IR_RESET_CODE)); // R2
  AST_IR_CAPTURE_PATTERN: assert property (@(posedge tck) disable iff (!trstN) (curSt == ST_CAP_IR) |=> (irShift == IR_CAPTURE_CODE)); // R3
  AST_IR_UPDATE_LOADS: assert property (@(posedge tck) disable iff (!trstN) (curSt == ST_UPD_IR) |=> (irReg == $past(irShift))); // R3

endmodule

// File: rtl/testPortPath.sv
module testPortPath
  import testPortPkg::*;
#(
  parameter int              BS_W        = 8,
  parameter logic [31:0]     ID_CODE     = 32'h1A5C_0E3B,
  parameter int              CTL_W       = 8,
  parameter int              BIST_CYCLES = 10240,
  parameter logic [CTL_W-1:0] LFSR_TAPS  = 8'hB8
) (
  input  logic            tck,
  input  logic            trstN,
  input  logic            tdi,
  input  tapStb_t         stb,
  input  logic [BS_W-1:0] bsIn,
  output logic            tdo,
  output logic            tdoOe,
  output logic [BS_W-1:0] bsOut,
  output logic            bistBusy
);

  localparam int ID_W   = 32;
  localparam int STAT_W = CTL_W + 2;
  localparam int CNT_W  = $clog2(BIST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BIST_CYCLES - 1);

  logic [BS_W-1:0]   bsSh;
  logic [ID_W-1:0]   idSh;
  logic              bypBit;
  logic [CTL_W-1:0]  ctlSh;
  logic [CTL_W-1:0]  ctlReg;
  logic [STAT_W-1:0] statSh;
  logic [CTL_W-1:0]  sigReg;
  logic [CNT_W-1:0]  cycCnt;
  logic              bistDone;
  logic              drBit;
  logic              chainSel;

  function automatic logic [CTL_W-1:0] lfsrNext(input logic [CTL_W-1:0] s);
    return s[0] ? ((s >> 1) ^ LFSR_TAPS) : (s >> 1);
  endfunction

  assign chainSel = (stb.path == PATH_BSCAN) || (stb.path == PATH_IDCH);

  // boundary chain, shared by the plain and the identified variant
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      bsSh <= '0;
    end else if (stb.capDr && chainSel) begin
      bsSh <= bsIn;
    end else if (stb.shDr && chainSel) begin
      bsSh <= {tdi, bsSh[BS_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      bsOut <= '0;
    end else if (stb.updDr && (stb.path == PATH_BSCAN)) begin
      bsOut <= bsSh;
    end
  end

  // identification word sits between the chain and data out
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      idSh <= '0;
    end else if (stb.capDr && (stb.path == PATH_IDCH)) begin
      idSh <= ID_CODE;
    end else if (stb.shDr && (stb.path == PATH_IDCH)) begin
      idSh <= {bsSh[0], idSh[ID_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      bypBit <= 1'b0;
    end else if (stb.capDr && (stb.path == PATH_BYP)) begin
      bypBit <= 1'b0;
    end else if (stb.shDr && (stb.path == PATH_BYP)) begin
      bypBit <= tdi;
    end
  end

  // self-test control word: shadow shift stage plus held value
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      ctlSh  <= '0;
      ctlReg <= '0;
    end else if (stb.capDr && (stb.path == PATH_STCTL)) begin
      ctlSh <= ctlReg;
    end else if (stb.shDr && (stb.path == PATH_STCTL)) begin
      ctlSh <= {tdi, ctlSh[CTL_W-1:1]};
    end else if (stb.updDr && (stb.path == PATH_STCTL)) begin
      ctlReg <= ctlSh;
    end
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      statSh <= '0;
    end else if (stb.capDr && (stb.path == PATH_STAT)) begin
      statSh <= {bistDone, bistBusy, sigReg};
    end else if (stb.shDr && (stb.path == PATH_STAT)) begin
      statSh <= {tdi, statSh[STAT_W-1:1]};
    end
  end

  // self-test engine: fixed-length signature run
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      bistBusy <= 1'b0;
      bistDone <= 1'b0;
      cycCnt   <= '0;
      sigReg   <= '0;
    end else if (stb.bistGo) begin
      bistBusy <= 1'b1;
      bistDone <= 1'b0;
      cycCnt   <= '0;
      sigReg   <= ctlReg;
    end else if (bistBusy) begin
      sigReg <= lfsrNext(sigReg);
      cycCnt <= cycCnt + 1'b1;
      if (cycCnt == CNT_LAST) begin
        bistBusy <= 1'b0;
        bistDone <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (stb.path)
      PATH_BSCAN: drBit = bsSh[0];
      PATH_IDCH:  drBit = idSh[0];
      PATH_STAT:  drBit = statSh[0];
      PATH_STCTL: drBit = ctlSh[0];
      PATH_BYP:   drBit = bypBit;
      default:    drBit = 1'b0;
    endcase
  end

  // output stage on the falling edge
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoOe <= 1'b0;
    end else begin
      tdoOe <= stb.shDr || stb.shIr;
      if (stb.shDr)      tdo <= drBit;
      else if (stb.shIr) tdo <= stb.irBit;
    end
  end

  AST_OE_ONLY_SHIFT: assert property (@(posedge tck) disable iff (!trstN) tdoOe |-> (stb.shDr || stb.shIr)); // R11
  AST_BIST_START: assert property (@(posedge tck) disable iff (!trstN) stb.bistGo |=> (bistBusy && !bistDone)); // R9
  AST_BIST_END_DONE: assert property (@(posedge tck) disable iff (!trstN) $fell(bistBusy) |-> bistDone); // R9
  AST_BUSY_DONE_EXCL: assert property (@(posedge tck) disable iff (!trstN) !(bistBusy && bistDone)); // R9
  AST_ID_CAPTURE: assert property (@(posedge tck) disable iff (!trstN) (stb.capDr && (stb.path == PATH_IDCH)) |=> (idSh == ID_CODE)); // R6

endmodule

// File: rtl/testPortTop.sv
module testPortTop
  import testPortPkg::*;
#(
  parameter int               BS_W        = 8,
  parameter logic [31:0]      ID_CODE     = 32'h1A5C_0E3B,
  parameter int               CTL_W       = 8,
  parameter int               BIST_CYCLES = 10240,
  parameter logic [CTL_W-1:0] LFSR_TAPS   = 8'hB8
) (
  input  logic            tck,
  input  logic            trstN,
  input  logic            tms,
  input  logic            tdi,
  input  logic [BS_W-1:0] bsIn,
  output logic            tdo,
  output logic            tdoOe,
  output logic [BS_W-1:0] bsOut,
  output logic [2:0]      selPath,
  output logic            drCapture,
  output logic            drShift,
  output logic            drUpdate,
  output logic            bistBusy
);

  tapStb_t stb;

  testPortCtl uCtl (
    .tck   (tck),
    .trstN (trstN),
    .tms   (tms),
    .tdi   (tdi),
    .stb   (stb)
  );

  testPortPath #(
    .BS_W        (BS_W),
    .ID_CODE     (ID_CODE),
    .CTL_W       (CTL_W),
    .BIST_CYCLES (BIST_CYCLES),
    .LFSR_TAPS   (LFSR_TAPS)
  ) uPath (
    .tck      (tck),
    .trstN    (trstN),
    .tdi      (tdi),
    .stb      (stb),
    .bsIn     (bsIn),
    .tdo      (tdo),
    .tdoOe    (tdoOe),
    .bsOut    (bsOut),
    .bistBusy (bistBusy)
  );

  assign selPath   = stb.path;
  assign drCapture = stb.capDr;
  assign drShift   = stb.shDr;
  assign drUpdate  = stb.updDr;

endmodule

// File: tb/sim_testPortTop.sv
module sim_testPortTop;

  localparam int          BS_W  = 8;
  localparam logic [31:0] IDW   = 32'h1A5C_0E3B;
  localparam int          NCYC  = 10240;
  localparam logic [7:0]  TAPS  = 8'hB8;

  localparam int S_TLR = 0, S_RTI = 1, S_SELDR = 2, S_CAPDR = 3, S_SHDR = 4, S_EX1DR = 5,
                 S_PAUDR = 6, S_EX2DR = 7, S_UPDDR = 8, S_SELIR = 9, S_CAPIR = 10,
                 S_SHIR = 11, S_EX1IR = 12, S_PAUIR = 13, S_EX2IR = 14, S_UPDIR = 15;

  logic tck = 1'b0;
  logic trstN = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic [BS_W-1:0] bsIn = 8'h3C;
  logic tdo, tdoOe, drCapture, drShift, drUpdate, bistBusy;
  logic [BS_W-1:0] bsOut;
  logic [2:0] selPath;

  testPortTop u0 (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .bsIn(bsIn),
    .tdo(tdo), .tdoOe(tdoOe), .bsOut(bsOut), .selPath(selPath),
    .drCapture(drCapture), .drShift(drShift), .drUpdate(drUpdate), .bistBusy(bistBusy)
  );

  always #4 tck = ~tck;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  int mSt = S_TLR;
  bit [3:0] mIrSh = 4'b0001;
  bit [3:0] mIr = 4'hF;
  bit mQ[$];
  bit outBits[$];
  bit [7:0] mBsOut = 0, mCtl = 0, mSig = 0;
  bit mBusy = 0, mDone = 0, mTdo = 0, mOe = 0;
  int mCnt = 0;

  task automatic chkEq(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int nextOf(input int s, input bit t);
    case (s)
      S_TLR:   return t ? S_TLR : S_RTI;
      S_RTI:   return t ? S_SELDR : S_RTI;
      S_SELDR: return t ? S_SELIR : S_CAPDR;
      S_CAPDR, S_SHDR: return t ? S_EX1DR : S_SHDR;
      S_EX1DR: return t ? S_UPDDR : S_PAUDR;
      S_PAUDR: return t ? S_EX2DR : S_PAUDR;
      S_EX2DR: return t ? S_UPDDR : S_SHDR;
      S_SELIR: return t ? S_TLR : S_CAPIR;
      S_CAPIR, S_SHIR: return t ? S_EX1IR : S_SHIR;
      S_EX1IR: return t ? S_UPDIR : S_PAUIR;
      S_PAUIR: return t ? S_EX2IR : S_PAUIR;
      S_EX2IR: return t ? S_UPDIR : S_SHIR;
      default: return t ? S_SELDR : S_RTI;
    endcase
  endfunction

  function automatic int pathOf(input bit [3:0] ir);
    if (ir[3:2] == 2'b11) return 5;
    if (ir[3:2] == 2'b10) return 4;
    if (ir[3:2] == 2'b00) return (ir == 4'b0011) ? 1 : 0;
    return (ir == 4'b0101) ? 3 : 2;
  endfunction

  function automatic bit [7:0] lfsrRun(input bit [7:0] seed, input int n);
    bit [7:0] s = seed;
    for (int i = 0; i < n; i++) s = s[0] ? ((s >> 1) ^ TAPS) : (s >> 1);
    return s;
  endfunction

  task automatic modelRise(input bit t, input bit d);
    int old = mSt;
    int p = pathOf(mIr);
    bit startB = 0;
    if (old == S_CAPDR) begin
      mQ.delete();
      case (p)
        0: for (int i = 0; i < BS_W; i++) mQ.push_back(bsIn[i]);
        1: begin
          for (int i = 0; i < 32; i++) mQ.push_back(IDW[i]);
          for (int i = 0; i < BS_W; i++) mQ.push_back(bsIn[i]);
        end
        2: begin
          for (int i = 0; i < 8; i++) mQ.push_back(mSig[i]);
          mQ.push_back(mBusy);
          mQ.push_back(mDone);
        end
        3: for (int i = 0; i < 8; i++) mQ.push_back(mCtl[i]);
        default: mQ.push_back(1'b0);
      endcase
    end else if (old == S_SHDR) begin
      void'(mQ.pop_front());
      mQ.push_back((p == 4) ? 1'b0 : d);
    end else if (old == S_UPDDR) begin
      if (p == 0) for (int i = 0; i < BS_W; i++) mBsOut[i] = mQ[i];
      if (p == 3) for (int i = 0; i < 8; i++) mCtl[i] = mQ[i];
    end
    if (old == S_CAPIR) mIrSh = 4'b0001;
    else if (old == S_SHIR) mIrSh = {d, mIrSh[3:1]};
    else if (old == S_UPDIR) begin
      mIr = mIrSh;
      startB = (mIrSh == 4'b0100);
    end
    if (startB) begin
      mBusy = 1; mDone = 0; mCnt = 0; mSig = mCtl;
    end else if (mBusy) begin
      mSig = lfsrRun(mSig, 1);
      mCnt++;
      if (mCnt == NCYC) begin
        mBusy = 0; mDone = 1;
      end
    end
    mSt = nextOf(old, t);
    if (mSt == S_TLR) mIr = 4'hF;
  endtask

  task automatic tick(input bit t, input bit d);
    tms = t;
    tdi = d;
    @(posedge tck);
    modelRise(t, d);
    #1;
    chkEq("R12 capture strobe", drCapture, mSt == S_CAPDR);
    chkEq("R12 shift strobe", drShift, mSt == S_SHDR);
    chkEq("R12 update strobe", drUpdate, mSt == S_UPDDR);
    chkEq("R12 path select", selPath, pathOf(mIr));
    chkEq("R5 boundary outputs", bsOut, mBsOut);
    chkEq("R9 busy flag", bistBusy, mBusy);
    @(negedge tck);
    if (mSt == S_SHDR) begin
      mOe = 1; mTdo = mQ[0]; outBits.push_back(mTdo);
    end else if (mSt == S_SHIR) begin
      mOe = 1; mTdo = mIrSh[0]; outBits.push_back(mTdo);
    end else mOe = 0;
    #1;
    chkEq("R11 output enable", tdoOe, mOe);
    if (mOe) chkEq("R11 serial out", tdo, mTdo);
  endtask

  task automatic loadIr(input bit [3:0] code, output logic [63:0] dout);
    outBits.delete();
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 4; i++) tick(i == 3, code[i]);
    tick(1, 0); tick(0, 0);
    dout = 0;
    for (int i = 0; i < outBits.size() && i < 64; i++) dout[i] = outBits[i];
  endtask

  task automatic scanDr(input int n, input logic [63:0] din, output logic [63:0] dout);
    outBits.delete();
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) tick(i == n - 1, din[i]);
    tick(1, 0); tick(0, 0);
    dout = 0;
    for (int i = 0; i < outBits.size() && i < 64; i++) dout[i] = outBits[i];
  endtask

  initial begin
    logic [63:0] o;
    repeat (2) @(negedge tck);
    #1;
    chkEq("R1 reset path", selPath, 3'd5);
    chkEq("R1 reset enable", tdoOe, 1'b0);
    chkEq("R1 reset busy", bistBusy, 1'b0);
    chkEq("R1 reset outputs", bsOut, 8'h00);
    trstN = 1'b1;
    tick(0, 0);

    loadIr(4'b0010, o);
    chkEq("R3 capture pattern", o[3:0], 4'b0001);
    chkEq("R3 decoded boundary", selPath, 3'd0);
    bsIn = 8'h3C;
    scanDr(8, 64'hA5, o);
    chkEq("R5 captured inputs", o[7:0], 8'h3C);
    chkEq("R5 update value", bsOut, 8'hA5);

    loadIr(4'b0011, o);
    bsIn = 8'hC7;
    scanDr(40, 64'h12_3456_789A, o);
    chkEq("R6 identification word", o[31:0], IDW);
    chkEq("R6 chain tail", o[39:32], 8'hC7);
    chkEq("R6 outputs kept", bsOut, 8'hA5);

    loadIr(4'b1001, o);
    scanDr(8, 64'hFF, o);
    chkEq("R7 zero path", o[7:0], 8'h00);

    loadIr(4'b1101, o);
    scanDr(8, 64'hB6, o);
    chkEq("R4 bypass delay", o[7:0], 8'h6C);

    loadIr(4'b0101, o);
    scanDr(8, 64'h5D, o);
    chkEq("R8 control after reset", o[7:0], 8'h00);
    scanDr(8, 64'h5D, o);
    chkEq("R8 control readback", o[7:0], 8'h5D);

    loadIr(4'b0100, o);
    chkEq("R9 started", bistBusy, 1'b1);
    scanDr(10, 64'h0, o);
    chkEq("R10 running flags", o[9:8], 2'b01);
    while (mBusy && mCnt < NCYC - 3) tick(0, 0);
    scanDr(10, 64'h0, o);
    chkEq("R9 capture on final step", o[9:0], {2'b01, lfsrRun(8'h5D, NCYC - 1)});
    scanDr(10, 64'h0, o);
    chkEq("R9 finished signature", o[9:0], {2'b10, lfsrRun(8'h5D, NCYC)});
    chkEq("R9 idle after run", bistBusy, 1'b0);
    loadIr(4'b0111, o);
    scanDr(10, 64'h0, o);
    chkEq("R10 status alias", o[9:0], {2'b10, lfsrRun(8'h5D, NCYC)});

    loadIr(4'b0000, o);
    tick(1, 0); tick(0, 0); tick(0, 0);
    repeat (4) tick(1, 0);
    chkEq("R2 four highs not enough", selPath, 3'd0);
    tick(1, 0);
    chkEq("R2 five highs", selPath, 3'd5);
    tick(0, 0);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(1, 0); tick(0, 0);
    repeat (5) tick(1, 0);
    chkEq("R2 from pause-IR", selPath, 3'd5);

    for (int k = 0; k < 600; k++) begin
      bsIn = 8'($urandom);
      tick(($urandom % 3) == 0, 1'($urandom));
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge tck);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule